// File: doc/BRIEF.md
# Clock Output Power-Management Controller

This block sits between a set of already-generated clocks and the pads that carry them. For every output it decides whether the clock toggles, is held low, or is released to high impedance. Four classes of output are handled: single-ended clocks, differential SRC pairs, one differential SATA pair, and two dual-purpose single-ended lines. The dual-purpose lines double as strap pins before start-up.

A power-good/power-down input controls start-up and power-down. Its first rising edge captures the strap inputs, and the block then starts. After that, a low level on the input means power-down and a high level means normal running. The power state is combined with per-output register enables, per-output run-in-power-down bits, two active-low bank enable pins and a latched test strap.

Each output has its own clock domain. Every start or stop request passes through a two-flop synchronizer in that domain. The gate enable then changes only while the gated phase of the clock is low, so no output ever emits a shortened pulse.

Top module: `clkpm_top`

## Requirements
- R1: `straps_o` is 0 after reset. On the first rising edge of `pwrgd_i` it captures `strap_i`. Later edges of `pwrgd_i` never change it. Strap bit positions: 0 mode0, 1 mode1, 2 fs0, 3 fs1, 4 spread enable, 5 test select.
- R2: Before the first `pwrgd_i` assertion, the following outputs are driven low: single-ended, SRC and SATA. The two dual-purpose outputs are at high impedance (`lio_oe_o`=0).
- R3: With `pwrgd_i` high, single-ended output i toggles when `se_en_i[i]`=1 and is driven low when `se_en_i[i]`=0.
- R4: In power-down, single-ended output i keeps toggling only if both `se_run_i[i]`=1 and `se_en_i[i]`=1; otherwise it is low.
- R5: `oe_a_ni`=1 forces SRC pairs 0 and 1 to low/low. `oe_b_ni`=1 forces SRC pairs 2 and 3 to low/low. A pair in a bank whose pin is 0 runs when it is otherwise enabled.
- R6: An SRC pair is low/low in power-down, and whenever its `src_en_i` bit is 0, whatever the bank pins are.
- R7: The SATA pair toggles only when `pwrgd_i` is high and `sata_en_i`=1. In every other case both legs are low.
- R8: With `pwrgd_i` high, dual-purpose output j toggles when `lio_en_i[j]`=1 and is driven low when `lio_en_i[j]`=0.
- R9: In power-down, dual-purpose output j behaves as follows:
  - `lio_run_i[j]`=0: high impedance, whatever `lio_en_i[j]` is.
  - `lio_run_i[j]`=1 and `lio_en_i[j]`=1: toggles.
  - `lio_run_i[j]`=1 and `lio_en_i[j]`=0: driven low.
- R10: A later high level of `pwrgd_i` leaves power-down, and every output returns to its running-state behaviour.
- R11: When the latched test strap (bit 5) is 1, every output enable is 0. This overrides all other controls.
- R12: Gating never shortens a pulse. A gated true output rises only with its clock's rising edge and falls only with its clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwrgd_i | input | 1 | Power-good / power-down level (asynchronous) |
| strap_i | input | STRAP_W | Raw strap levels |
| straps_o | output | STRAP_W | Straps latched at first power-good |
| se_en_i | input | NUM_SE | Single-ended register enables |
| se_run_i | input | NUM_SE | Single-ended run-in-power-down bits |
| src_en_i | input | NUM_SRC | SRC pair register enables |
| oe_a_ni | input | 1 | Active-low enable, SRC bank A (lower half) |
| oe_b_ni | input | 1 | Active-low enable, SRC bank B (upper half) |
| sata_en_i | input | 1 | SATA register enable |
| lio_en_i | input | NUM_LIO | Dual-purpose output register enables |
| lio_run_i | input | NUM_LIO | Dual-purpose run-in-power-down bits |
| se_clk_i | input | NUM_SE | Source clocks, single-ended |
| src_clk_i | input | NUM_SRC | Source clocks, SRC pairs |
| sata_clk_i | input | 1 | Source clock, SATA |
| lio_clk_i | input | NUM_LIO | Source clocks, dual-purpose outputs |
| se_o | output | NUM_SE | Gated single-ended clocks |
| se_oe_o | output | NUM_SE | Single-ended output enables |
| src_p_o | output | NUM_SRC | SRC true legs |
| src_n_o | output | NUM_SRC | SRC complement legs |
| src_oe_o | output | NUM_SRC | SRC output enables |
| sata_p_o | output | 1 | SATA true leg |
| sata_n_o | output | 1 | SATA complement leg |
| sata_oe_o | output | 1 | SATA output enable |
| lio_o | output | NUM_LIO | Gated dual-purpose clocks |
| lio_oe_o | output | NUM_LIO | Dual-purpose output enables |

## Verification
The hardest states to reach from the ports are two. The first is the test tri-state: the test strap is only captured on the very first power-good edge. The second is that later power cycles leave the straps untouched. The stimulus changes `strap_i` between power cycles and checks that `straps_o` holds its first value. It then reaches test mode by a fresh reset followed by a first power-good edge with bit 5 set. The dual-purpose outputs in power-down need all four combinations of enable and run bit, and each is visited while `pwrgd_i` is held low.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
  localparam int unsigned STRAP_W    = 6;
  localparam int unsigned STRAP_TEST = 5;

  typedef struct packed {
    logic started;  // first power-good seen
    logic pg_hi;    // started and power-good high
    logic test;     // latched test strap
  } pm_state_t;
endpackage

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrgd_i,
  input  logic [STRAP_W-1:0] strap_i,
  output pm_state_t          state_o,
  output logic [STRAP_W-1:0] straps_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] pg_sync;
  logic                   pg_s, pg_d, started_q;
  logic [STRAP_W-1:0]     straps_q;
  logic                   first_rise;

  assign pg_s       = pg_sync[MSB];
  assign first_rise = pg_s & ~pg_d & ~started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_sync   <= '0;
      pg_d      <= 1'b0;
      started_q <= 1'b0;
      straps_q  <= '0;
    end else begin
      pg_sync <= {pg_sync[SYNC_STAGES-2:0], pwrgd_i};
      pg_d    <= pg_s;
      if (first_rise) begin
        started_q <= 1'b1;
        straps_q  <= strap_i;
      end
    end
  end

  assign state_o.started = started_q;
  assign state_o.pg_hi   = started_q & pg_s;
  assign state_o.test    = straps_q[STRAP_TEST];
  assign straps_o        = straps_q;

  // R1
  started_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> started_q);

  // R1
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(started_q)) |-> $stable(straps_q));
endmodule

// File: rtl/clkpm_policy.sv
module clkpm_policy
  import clkpm_pkg::*;
#(
  parameter int unsigned NUM_SE  = 4,
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned NUM_LIO = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pm_state_t          state_i,
  input  logic [NUM_SE-1:0]  se_en_i,
  input  logic [NUM_SE-1:0]  se_run_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               oe_a_ni,
  input  logic               oe_b_ni,
  input  logic               sata_en_i,
  input  logic [NUM_LIO-1:0] lio_en_i,
  input  logic [NUM_LIO-1:0] lio_run_i,
  output logic [NUM_SE-1:0]  se_run_o,
  output logic [NUM_SRC-1:0] src_run_o,
  output logic               sata_run_o,
  output logic [NUM_LIO-1:0] lio_run_o,
  output logic [NUM_LIO-1:0] lio_hiz_o
);
  localparam int unsigned BANK_SPLIT = NUM_SRC / 2;

  logic               pd;
  logic [NUM_SE-1:0]  se_d;
  logic [NUM_SRC-1:0] src_d;
  logic [NUM_LIO-1:0] lio_d, hiz_d;
  logic [NUM_SE-1:0]  se_run_q;
  logic [NUM_SRC-1:0] src_run_q;
  logic               sata_run_q;
  logic [NUM_LIO-1:0] lio_run_q, lio_hiz_q;

  assign pd = state_i.started & ~state_i.pg_hi;

  always_comb begin
    for (int i = 0; i < NUM_SE; i++)
      se_d[i] = state_i.started & se_en_i[i] & (state_i.pg_hi | se_run_i[i]);
    for (int j = 0; j < NUM_LIO; j++) begin
      lio_d[j] = state_i.started & lio_en_i[j] & (state_i.pg_hi | lio_run_i[j]);
      hiz_d[j] = ~state_i.started | (pd & ~lio_run_i[j]);
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic bank_off;
    if (k < BANK_SPLIT) begin : g_a
      assign bank_off = oe_a_ni;
    end else begin : g_b
      assign bank_off = oe_b_ni;
    end
    assign src_d[k] = state_i.pg_hi & src_en_i[k] & ~bank_off;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      se_run_q   <= '0;
      src_run_q  <= '0;
      sata_run_q <= 1'b0;
      lio_run_q  <= '0;
      lio_hiz_q  <= '1;
    end else begin
      se_run_q   <= se_d;
      src_run_q  <= src_d;
      sata_run_q <= state_i.pg_hi & sata_en_i;
      lio_run_q  <= lio_d;
      lio_hiz_q  <= hiz_d;
    end
  end

  assign se_run_o   = se_run_q;
  assign src_run_o  = src_run_q;
  assign sata_run_o = sata_run_q;
  assign lio_run_o  = lio_run_q;
  assign lio_hiz_o  = lio_hiz_q;

  // R2
  prestart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_i.started |=> (se_run_q == '0 && src_run_q == '0 && !sata_run_q && lio_hiz_q == '1));

  // R6
  src_pd_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i.started && !state_i.pg_hi) |=> (src_run_q == '0));
endmodule

// File: rtl/clkpm_gate.sv
module clkpm_gate #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HIZ_RST     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hiz_i,
  input  logic test_i,
  output logic clk_o,
  output logic clk_n_o,
  output logic oe_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] run_s, hiz_s;
  logic                   en_p_q, en_n_q, hiz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_s  <= '0;
      hiz_s  <= {SYNC_STAGES{HIZ_RST}};
      en_n_q <= 1'b0;
    end else begin
      run_s  <= {run_s[SYNC_STAGES-2:0], run_i};
      hiz_s  <= {hiz_s[SYNC_STAGES-2:0], hiz_i};
      en_n_q <= run_s[MSB];  // complement leg is low while clock is high
    end
  end

  // true leg enable moves only while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_p_q <= 1'b0;
      hiz_q  <= HIZ_RST;
    end else begin
      en_p_q <= run_s[MSB];
      hiz_q  <= hiz_s[MSB];
    end
  end

  assign clk_o   = clk_i & en_p_q;
  assign clk_n_o = ~clk_i & en_n_q;
  assign oe_o    = ~(hiz_q | test_i);
endmodule

// File: rtl/clkpm_top.sv
module clkpm_top
  import clkpm_pkg::*;
#(
  parameter int unsigned NUM_SE      = 4,
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned NUM_LIO     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrgd_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] straps_o,
  input  logic [NUM_SE-1:0]  se_en_i,
  input  logic [NUM_SE-1:0]  se_run_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               oe_a_ni,
  input  logic               oe_b_ni,
  input  logic               sata_en_i,
  input  logic [NUM_LIO-1:0] lio_en_i,
  input  logic [NUM_LIO-1:0] lio_run_i,
  input  logic [NUM_SE-1:0]  se_clk_i,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               sata_clk_i,
  input  logic [NUM_LIO-1:0] lio_clk_i,
  output logic [NUM_SE-1:0]  se_o,
  output logic [NUM_SE-1:0]  se_oe_o,
  output logic [NUM_SRC-1:0] src_p_o,
  output logic [NUM_SRC-1:0] src_n_o,
  output logic [NUM_SRC-1:0] src_oe_o,
  output logic               sata_p_o,
  output logic               sata_n_o,
  output logic               sata_oe_o,
  output logic [NUM_LIO-1:0] lio_o,
  output logic [NUM_LIO-1:0] lio_oe_o
);
  pm_state_t          state;
  logic [NUM_SE-1:0]  se_run;
  logic [NUM_SRC-1:0] src_run;
  logic               sata_run;
  logic [NUM_LIO-1:0] lio_run, lio_hiz;
  logic [NUM_SE-1:0]  unused_se_n;
  logic [NUM_LIO-1:0] unused_lio_n;

  clkpm_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk_i, .rst_ni, .pwrgd_i, .strap_i,
    .state_o(state), .straps_o
  );

  clkpm_policy #(.NUM_SE(NUM_SE), .NUM_SRC(NUM_SRC), .NUM_LIO(NUM_LIO)) u_policy (
    .clk_i, .rst_ni, .state_i(state),
    .se_en_i, .se_run_i, .src_en_i, .oe_a_ni, .oe_b_ni, .sata_en_i,
    .lio_en_i, .lio_run_i,
    .se_run_o(se_run), .src_run_o(src_run), .sata_run_o(sata_run),
    .lio_run_o(lio_run), .lio_hiz_o(lio_hiz)
  );

  for (genvar i = 0; i < NUM_SE; i++) begin : g_se
    clkpm_gate #(.SYNC_STAGES(SYNC_STAGES), .HIZ_RST(1'b0)) u_gate (
      .clk_i(se_clk_i[i]), .rst_ni, .run_i(se_run[i]), .hiz_i(1'b0),
      .test_i(state.test), .clk_o(se_o[i]), .clk_n_o(unused_se_n[i]),
      .oe_o(se_oe_o[i])
    );
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    clkpm_gate #(.SYNC_STAGES(SYNC_STAGES), .HIZ_RST(1'b0)) u_gate (
      .clk_i(src_clk_i[k]), .rst_ni, .run_i(src_run[k]), .hiz_i(1'b0),
      .test_i(state.test), .clk_o(src_p_o[k]), .clk_n_o(src_n_o[k]),
      .oe_o(src_oe_o[k])
    );
  end

  clkpm_gate #(.SYNC_STAGES(SYNC_STAGES), .HIZ_RST(1'b0)) u_sata (
    .clk_i(sata_clk_i), .rst_ni, .run_i(sata_run), .hiz_i(1'b0),
    .test_i(state.test), .clk_o(sata_p_o), .clk_n_o(sata_n_o),
    .oe_o(sata_oe_o)
  );

  for (genvar j = 0; j < NUM_LIO; j++) begin : g_lio
    clkpm_gate #(.SYNC_STAGES(SYNC_STAGES), .HIZ_RST(1'b1)) u_gate (
      .clk_i(lio_clk_i[j]), .rst_ni, .run_i(lio_run[j]), .hiz_i(lio_hiz[j]),
      .test_i(state.test), .clk_o(lio_o[j]), .clk_n_o(unused_lio_n[j]),
      .oe_o(lio_oe_o[j])
    );
  end
endmodule

// File: tb/tb_clkpm_top.sv
`timescale 1ns/1ps
module tb_clkpm_top;
  localparam logic [1:0] L = 2'd0, R = 2'd1, Z = 2'd2, X = 2'd3;

  typedef struct packed {
    logic [3:0][1:0] se;
    logic [3:0][1:0] src;
    logic [1:0]      sata;
    logic [1:0][1:0] lio;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwrgd_i = 1'b0;
  logic [5:0] strap_i = 6'b001101;
  logic [5:0] straps_o;
  logic [3:0] se_en_i = 4'hF, se_run_i = 4'h0, src_en_i = 4'hF;
  logic oe_a_ni = 1'b0, oe_b_ni = 1'b0, sata_en_i = 1'b1;
  logic [1:0] lio_en_i = 2'b11, lio_run_i = 2'b00;
  logic [3:0] se_o, se_oe_o, src_p_o, src_n_o, src_oe_o;
  logic sata_p_o, sata_n_o, sata_oe_o;
  logic [1:0] lio_o, lio_oe_o;

  int total = 0, bad = 0, glitch = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  clkpm_top dut (
    .clk_i(clk), .rst_ni, .pwrgd_i, .strap_i, .straps_o,
    .se_en_i, .se_run_i, .src_en_i, .oe_a_ni, .oe_b_ni, .sata_en_i,
    .lio_en_i, .lio_run_i,
    .se_clk_i({4{clk}}), .src_clk_i({4{clk}}), .sata_clk_i(clk), .lio_clk_i({2{clk}}),
    .se_o, .se_oe_o, .src_p_o, .src_n_o, .src_oe_o,
    .sata_p_o, .sata_n_o, .sata_oe_o, .lio_o, .lio_oe_o
  );

  function automatic logic [1:0] dec(logic oe, logic hi, logic lo);
    if (!oe) return Z;
    if (hi && !lo) return R;
    if (!hi && !lo) return L;
    return X;
  endfunction

  function automatic logic [1:0] dec_d(logic oe, logic phi, logic plo, logic nhi, logic nlo);
    logic [1:0] s;
    s = dec(oe, phi, plo);
    if (s == R && !(!nhi && nlo)) return X;
    if (s == L && (nhi || nlo)) return X;
    return s;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // R12: gated true output edges must coincide with its clock's edges
  always @(posedge se_o[0]) if (!clk) glitch++;
  always @(negedge se_o[0]) if (clk) glitch++;

  // monitor
  initial begin
    logic [3:0] se_hi, se_lo, oe_se, sp_hi, sp_lo, sn_hi, sn_lo, oe_src;
    logic [1:0] l_hi, l_lo, oe_l;
    logic sa_ph, sa_pl, sa_nh, sa_nl, oe_sa;
    exp_t e;
    forever begin
      wait (exp_q.size() > 0);
      @(posedge clk); #1;
      se_hi = se_o; sp_hi = src_p_o; sn_hi = src_n_o; l_hi = lio_o;
      sa_ph = sata_p_o; sa_nh = sata_n_o;
      oe_se = se_oe_o; oe_src = src_oe_o; oe_l = lio_oe_o; oe_sa = sata_oe_o;
      @(negedge clk); #1;
      se_lo = se_o; sp_lo = src_p_o; sn_lo = src_n_o; l_lo = lio_o;
      sa_pl = sata_p_o; sa_nl = sata_n_o;
      e = exp_q[0];
      for (int i = 0; i < 4; i++) begin
        chk(tag_q[0], $sformatf("se[%0d]", i), 8'(dec(oe_se[i], se_hi[i], se_lo[i])), 8'(e.se[i]));
        chk(tag_q[0], $sformatf("src[%0d]", i),
            8'(dec_d(oe_src[i], sp_hi[i], sp_lo[i], sn_hi[i], sn_lo[i])), 8'(e.src[i]));
      end
      chk(tag_q[0], "sata", 8'(dec_d(oe_sa, sa_ph, sa_pl, sa_nh, sa_nl)), 8'(e.sata));
      for (int j = 0; j < 2; j++)
        chk(tag_q[0], $sformatf("lio[%0d]", j), 8'(dec(oe_l[j], l_hi[j], l_lo[j])), 8'(e.lio[j]));
      void'(tag_q.pop_front());
      void'(exp_q.pop_front());
    end
  end

  // driver: settle, push expectation, wait for monitor
  task automatic expect_now(string tag, logic [3:0][1:0] se, logic [3:0][1:0] src,
                            logic [1:0] sata, logic [1:0][1:0] lio);
    exp_t e;
    repeat (14) @(posedge clk);
    e.se = se; e.src = src; e.sata = sata; e.lio = lio;
    tag_q.push_back(tag);
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    expect_now("R2", {L,L,L,L}, {L,L,L,L}, L, {Z,Z});
    chk("R1", "straps before start", 8'(straps_o), 8'h00);

    pwrgd_i = 1'b1;
    expect_now("R3 R5 R7 R8", {R,R,R,R}, {R,R,R,R}, R, {R,R});
    chk("R1", "straps latched", 8'(straps_o), 8'h0D);

    strap_i = 6'b110010;
    pwrgd_i = 1'b0; repeat (14) @(posedge clk);
    pwrgd_i = 1'b1; repeat (14) @(posedge clk);
    chk("R1", "straps after re-cycle", 8'(straps_o), 8'h0D);

    se_en_i = 4'b0101; lio_en_i = 2'b01; sata_en_i = 1'b0;
    expect_now("R3 R7 R8", {L,R,L,R}, {R,R,R,R}, L, {L,R});

    se_en_i = 4'hF; lio_en_i = 2'b11; sata_en_i = 1'b1; oe_a_ni = 1'b1;
    expect_now("R5 bankA", {R,R,R,R}, {R,R,L,L}, R, {R,R});
    oe_a_ni = 1'b0; oe_b_ni = 1'b1;
    expect_now("R5 bankB", {R,R,R,R}, {L,L,R,R}, R, {R,R});
    oe_b_ni = 1'b0; src_en_i = 4'b1110;
    expect_now("R6 enable", {R,R,R,R}, {R,R,R,L}, R, {R,R});

    src_en_i = 4'hF; se_run_i = 4'b0011; lio_run_i = 2'b11; lio_en_i = 2'b01;
    pwrgd_i = 1'b0;
    expect_now("R4 R6 R7 R9", {L,L,R,R}, {L,L,L,L}, L, {L,R});
    lio_run_i = 2'b01;
    expect_now("R9 hiz", {L,L,R,R}, {L,L,L,L}, L, {Z,R});
    lio_en_i = 2'b11; lio_run_i = 2'b00;
    expect_now("R9 en ignored", {L,L,R,R}, {L,L,L,L}, L, {Z,Z});

    pwrgd_i = 1'b1;
    expect_now("R10", {R,R,R,R}, {R,R,R,R}, R, {R,R});

    @(negedge clk);
    rst_ni = 1'b0; pwrgd_i = 1'b0; strap_i = 6'b100000;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    pwrgd_i = 1'b1;
    expect_now("R11", {Z,Z,Z,Z}, {Z,Z,Z,Z}, Z, {Z,Z});
    chk("R1", "test strap latched", 8'(straps_o), 8'h20);

    chk("R12", "shortened pulses", 8'(glitch), 8'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule